// File: doc/BRIEF.md
# Gain-Selectable SAR Quantizer Sequencer

This block is the digital control for a 4-bit successive-approximation quantizer whose loop feedback gain is set by the way two capacitor arrays are shared between the sampling and conversion phases. A one-bit gain-mode input picks the arrangement. In the above-unity mode the input is sampled onto both arrays and resolved on the first array alone. In the unity-or-below mode the input is sampled onto the first array alone and resolved on both arrays. The mode is captured when a conversion is accepted and is held for that whole conversion.

Each conversion starts with a one-cycle start pulse. The block clears its working register, holds the sampling switches closed for a set number of cycles, and then tries the result bits one at a time, starting with the most significant. For each trial it drives the binary-weighted segment switches to the bits already kept plus the bit under trial. After the comparator has had time to regenerate, it keeps or drops that bit according to the single comparator output. Once the least significant decision is made, it publishes the 4-bit code and pulses an end-of-conversion flag. The whole sequence must fit within half of the quantizer's sample period, so that the feedback DAC logic still has time to act on the result.

Top module: `sarq_ctrl`

## Requirements
- R1: After reset, busy, eoc, sample_on, arr1_on and arr2_on are 0, and seg_on and result are all zeros.
- R2: A start pulse while idle sets busy in the next cycle. sample_on is then high for exactly SAMP_CYC cycles (default 2), with seg_on all zeros during those cycles.
- R3: With gain_hi=1 captured at start, sampling uses both arrays (arr1_on=1, arr2_on=1) and the bit trials use array 1 only (arr1_on=1, arr2_on=0).
- R4: With gain_hi=0 captured at start, sampling uses array 1 only (arr1_on=1, arr2_on=0) and the bit trials use both arrays (arr1_on=1, arr2_on=1).
- R5: gain_hi is sampled only in the cycle a start is accepted. A change while busy has no effect on the array selection until the next accepted start.
- R6: The working bits are cleared at every accepted start. The first trial code on seg_on is therefore 4'b1000, whatever the previous result was.
- R7: Bits are tried from bit 3 down to bit 0. Each trial drives seg_on = (bits kept so far) | (1 << k) for REGEN_CYC cycles (default 1). cmp_hi is sampled at the clock edge that ends that window, and bit k is kept when cmp_hi=1 and cleared otherwise.
- R8: seg_on[3], seg_on[2], seg_on[1] and seg_on[0] switch segments of weight 8, 4, 2 and 1 units. result is the unsigned sum of the kept bits' weights.
- R9: eoc is high for exactly one cycle, in the cycle after the bit-0 decision. result takes the new code in that same cycle and holds it until the next eoc.
- R10: A start pulse while busy is ignored. The running conversion is not restarted and no extra eoc is produced.
- R11: eoc appears SAMP_CYC + 4*REGEN_CYC clock edges after the edge that accepts start (6 with defaults). This must not exceed PERIOD_CYC/2 (8 with defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a conversion |
| gain_hi | input | 1 | 1 selects feedback gain above unity, 0 selects unity or below |
| cmp_hi | input | 1 | Comparator: 1 when the input is above the present DAC level |
| sample_on | output | 1 | Sampling switches closed |
| arr1_on | output | 1 | Array 1 connected |
| arr2_on | output | 1 | Array 2 connected |
| seg_on | output | 4 | Segment switches, weights 8/4/2/1 from bit 3 down |
| result | output | 4 | Last completed conversion code |
| eoc | output | 1 | End-of-conversion pulse |
| busy | output | 1 | A conversion is in progress |

## Verification
Conversions are run over input levels of zero, mid-scale, exact segment thresholds, one below a threshold, full scale and above full scale. Comparing the whole trial-code sequence for these levels tells a correct keep/drop decision apart from an inverted decision, a skipped bit or a bit left set from an earlier conversion. Each level is converted in both gain modes, so that a swapped or stuck array selection shows up in either phase. Some runs also flip the gain input part-way through, or pulse start again while busy, to show that neither the mode capture nor the sequence can be disturbed.

// File: rtl/sarq_pkg.sv
package sarq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2
  } sarq_phase_e;

  typedef struct packed {
    logic a1;
    logic a2;
  } sarq_arr_t;

  // Array use per phase: above-unity gain samples on both, converts on one;
  // unity-or-below samples on one, converts on both.
  function automatic sarq_arr_t arr_pick(input logic gain_hi, input logic sampling);
    sarq_arr_t r;
    r.a1 = 1'b1;
    r.a2 = sampling ? gain_hi : ~gain_hi;
    return r;
  endfunction

endpackage

// File: rtl/sarq_mode_map.sv
module sarq_mode_map
  import sarq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  sarq_phase_e phase,
  input  logic        gain_q,
  output logic        arr1_on,
  output logic        arr2_on
);

  sarq_arr_t pick;

  always_comb begin
    pick    = arr_pick(gain_q, phase == PH_SAMPLE);
    arr1_on = (phase != PH_IDLE) & pick.a1;
    arr2_on = (phase != PH_IDLE) & pick.a2;
  end

  // Array 2 must change state across the sample-to-trial boundary in either mode.
  AST_ARRAY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRIAL && $past(phase) == PH_SAMPLE) |-> (arr2_on != $past(arr2_on))); // R3 R4

  AST_ARRAY1_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> arr1_on); // R3 R4

endmodule

// File: rtl/sarq_seq.sv
module sarq_seq
  import sarq_pkg::*;
#(
  parameter int NBITS     = 4,
  parameter int SAMP_CYC  = 2,
  parameter int REGEN_CYC = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output sarq_phase_e              phase,
  output logic [$clog2(NBITS)-1:0] bit_idx,
  output logic                     start_acc,
  output logic                     decide,
  output logic                     last_dec
);

  localparam int IW   = $clog2(NBITS);
  localparam int CMAX = (SAMP_CYC > REGEN_CYC) ? SAMP_CYC : REGEN_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SAMP_LAST  = CW'(SAMP_CYC - 1);
  localparam logic [CW-1:0] REGEN_LAST = CW'(REGEN_CYC - 1);
  localparam logic [IW-1:0] MSB_IDX    = IW'(NBITS - 1);

  sarq_phase_e ph_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;

  always_comb begin
    start_acc = start && (ph_q == PH_IDLE);
    decide    = (ph_q == PH_TRIAL) && (cnt_q == REGEN_LAST);
    last_dec  = decide && (idx_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_acc) begin
            ph_q  <= PH_SAMPLE;
            cnt_q <= '0;
          end
        end
        PH_SAMPLE: begin
          if (cnt_q == SAMP_LAST) begin
            ph_q  <= PH_TRIAL;
            cnt_q <= '0;
            idx_q <= MSB_IDX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_TRIAL: begin
          if (decide) begin
            cnt_q <= '0;
            if (idx_q == '0) ph_q <= PH_IDLE;
            else             idx_q <= idx_q - 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase   = ph_q;
  assign bit_idx = idx_q;

  AST_TRIAL_FROM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TRIAL && $past(ph_q) == PH_SAMPLE) |-> (idx_q == MSB_IDX)); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TRIAL && start) |=> (ph_q != PH_SAMPLE)); // R10

  AST_SAMPLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && start) |=> (ph_q == PH_SAMPLE)); // R2

endmodule

// File: rtl/sarq_sar.sv
module sarq_sar
  import sarq_pkg::*;
#(
  parameter int NBITS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  sarq_phase_e              phase,
  input  logic [$clog2(NBITS)-1:0] bit_idx,
  input  logic                     start_acc,
  input  logic                     decide,
  input  logic                     last_dec,
  input  logic                     cmp_hi,
  output logic [NBITS-1:0]         seg_on,
  output logic [NBITS-1:0]         result,
  output logic                     eoc
);

  localparam int IW = $clog2(NBITS);
  localparam logic [NBITS-1:0] MSB_WORD = {1'b1, {(NBITS-1){1'b0}}};

  function automatic logic [NBITS-1:0] trial_word(input logic [NBITS-1:0] kept,
                                                  input logic [IW-1:0]    idx);
    return kept | (NBITS'(1) << idx);
  endfunction

  logic [NBITS-1:0] sar_q, sar_nxt, res_q;
  logic             eoc_q;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    always_comb begin
      if (start_acc)                        sar_nxt[b] = 1'b0;
      else if (decide && bit_idx == IW'(b)) sar_nxt[b] = cmp_hi;
      else                                  sar_nxt[b] = sar_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
      eoc_q <= 1'b0;
    end else begin
      sar_q <= sar_nxt;
      eoc_q <= last_dec;
      if (last_dec) res_q <= sar_nxt;
    end
  end

  assign seg_on = (phase == PH_TRIAL) ? trial_word(sar_q, bit_idx) : '0;
  assign result = res_q;
  assign eoc    = eoc_q;

  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_q |=> !eoc_q); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_q |-> $stable(res_q)); // R9

  AST_SAMPLE_SEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAMPLE) |-> (seg_on == '0)); // R2

  AST_FIRST_TRIAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRIAL && $past(phase) == PH_SAMPLE) |-> (seg_on == MSB_WORD)); // R6

endmodule

// File: rtl/sarq_ctrl.sv
module sarq_ctrl
  import sarq_pkg::*;
#(
  parameter int NBITS      = 4,
  parameter int SAMP_CYC   = 2,
  parameter int REGEN_CYC  = 1,
  parameter int PERIOD_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             gain_hi,
  input  logic             cmp_hi,
  output logic             sample_on,
  output logic             arr1_on,
  output logic             arr2_on,
  output logic [NBITS-1:0] seg_on,
  output logic [NBITS-1:0] result,
  output logic             eoc,
  output logic             busy
);

  localparam int IW         = $clog2(NBITS);
  localparam int BUDGET_CYC = PERIOD_CYC / 2;
  localparam int LW         = $clog2(SAMP_CYC + NBITS * REGEN_CYC + BUDGET_CYC + 2);

  sarq_phase_e   phase;
  logic [IW-1:0] bit_idx;
  logic          start_acc, decide, last_dec;
  logic          gain_q;

  sarq_seq #(
    .NBITS    (NBITS),
    .SAMP_CYC (SAMP_CYC),
    .REGEN_CYC(REGEN_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .phase    (phase),
    .bit_idx  (bit_idx),
    .start_acc(start_acc),
    .decide   (decide),
    .last_dec (last_dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gain_q <= 1'b0;
    else if (start_acc) gain_q <= gain_hi;
  end

  sarq_mode_map u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .gain_q (gain_q),
    .arr1_on(arr1_on),
    .arr2_on(arr2_on)
  );

  sarq_sar #(
    .NBITS(NBITS)
  ) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .bit_idx  (bit_idx),
    .start_acc(start_acc),
    .decide   (decide),
    .last_dec (last_dec),
    .cmp_hi   (cmp_hi),
    .seg_on   (seg_on),
    .result   (result),
    .eoc      (eoc)
  );

  assign sample_on = (phase == PH_SAMPLE);
  assign busy      = (phase != PH_IDLE);

  // Elapsed edges since the accepting edge, for the timing budget check.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_q <= '0;
    else if (start_acc) lat_q <= '0;
    else if (busy)      lat_q <= lat_q + 1'b1;
  end

  AST_GAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(gain_q)); // R5

  AST_WITHIN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (lat_q <= LW'(BUDGET_CYC))); // R11

endmodule

// File: tb/tb_sarq_ctrl.sv
`timescale 1ns/1ps
module tb_sarq_ctrl;

  localparam int NB  = 4;
  localparam int SC  = 2;
  localparam int RC  = 1;
  localparam int LAT = SC + NB * RC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic gain_hi = 1'b0;
  logic cmp_hi;
  logic sample_on, arr1_on, arr2_on, eoc, busy;
  logic [NB-1:0] seg_on, result;

  int vin = 0;
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_eoc = 0;
  bit finished = 1'b0;

  // Behavioural comparator: input in tenths of a unit, DAC level = code units.
  always_comb cmp_hi = (vin >= int'(seg_on) * 10);

  sarq_ctrl #(.NBITS(NB), .SAMP_CYC(SC), .REGEN_CYC(RC), .PERIOD_CYC(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .gain_hi(gain_hi), .cmp_hi(cmp_hi),
    .sample_on(sample_on), .arr1_on(arr1_on), .arr2_on(arr2_on), .seg_on(seg_on),
    .result(result), .eoc(eoc), .busy(busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          res;
    bit          g;
    logic [15:0] codes;
    int          t0;
  } item_t;
  item_t q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: collects per-conversion observations and scores them at eoc.
  bit s1, s2, c1, c2, prev_eoc;
  int samp_n;
  logic [15:0] obs_codes;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_on) begin s1 = arr1_on; s2 = arr2_on; samp_n++; end
      if (busy && !sample_on) begin
        c1 = arr1_on; c2 = arr2_on;
        obs_codes = {obs_codes[11:0], seg_on};
      end
      if (prev_eoc) check(!eoc, "R9 eoc width", int'(eoc), 0);
      if (eoc) begin
        n_eoc++;
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected eoc", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(int'(result) == it.res, "R8 result", int'(result), it.res);
          check(obs_codes == it.codes, "R7 trial sequence", int'(obs_codes), int'(it.codes));
          check(obs_codes[15:12] == 4'b1000, "R6 first trial", int'(obs_codes[15:12]), 8);
          check(cyc - it.t0 == LAT, "R11 latency", cyc - it.t0, LAT);
          check(samp_n == SC, "R2 sample length", samp_n, SC);
          if (it.g) begin
            check(s1 && s2, "R3 sample arrays", {s1, s2}, 3);
            check(c1 && !c2, "R3 convert arrays", {c1, c2}, 2);
          end else begin
            check(s1 && !s2, "R4 sample arrays", {s1, s2}, 2);
            check(c1 && c2, "R4 convert arrays", {c1, c2}, 3);
          end
        end
        samp_n = 0;
        obs_codes = '0;
      end
      prev_eoc = eoc;
    end
  end

  // Driver: pushes the expected outcome, then runs one conversion.
  task automatic convert(input int v, input bit g, input int flip_at, input int extra_at);
    item_t it;
    int kept = 0;
    it.codes = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      int code = kept | (1 << k);
      it.codes = {it.codes[11:0], 4'(code)};
      if (v >= code * 10) kept = code;
    end
    it.res = kept;
    it.g = g;
    it.t0 = 0;
    @(negedge clk);
    vin = v; gain_hi = g; start = 1'b1;
    q.push_back(it);
    @(posedge clk);
    #1 q[q.size() - 1].t0 = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy && sample_on, "R2 busy after start", {busy, sample_on}, 3);
    for (int i = 0; i < LAT + 3; i++) begin
      @(negedge clk);
      if (i == flip_at) gain_hi = ~gain_hi;
      start = (i == extra_at);
    end
    start = 1'b0;
    check(!busy, "R10 idle after one run", int'(busy), 0);
    check(int'(result) == kept, "R9 result held", int'(result), kept);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !eoc && !sample_on && !arr1_on && !arr2_on, "R1 reset controls",
          {busy, eoc, sample_on, arr1_on, arr2_on}, 0);
    check(seg_on == '0 && result == '0, "R1 reset data", int'({seg_on, result}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy, "R1 idle after reset", int'(busy), 0);

    convert(0,   1'b1, -1, -1);
    convert(80,  1'b0, -1, -1);
    convert(79,  1'b1, -1, -1);
    convert(150, 1'b0, -1, -1);
    convert(200, 1'b1, -1, -1);   // above full scale, clamps at 15
    convert(37,  1'b0, -1, -1);   // R6: previous result 15 must not leak
    convert(55,  1'b1, 1, -1);    // R5: gain flipped while busy
    convert(105, 1'b0, 2, -1);    // R5
    convert(123, 1'b1, -1, 2);    // R10: start while busy
    convert(64,  1'b0, -1, 0);    // R10
    convert(149, 1'b1, -1, -1);
    convert(10,  1'b0, -1, -1);

    repeat (4) @(negedge clk);
    check(q.size() == 0 && n_eoc == 12, "R10 eoc count", n_eoc, 12);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule